// File: doc/BRIEF.md
# Inter-core doorbell interrupt register

This block is a one-word register through which a host processor rings interrupts on a single target core. Each low bit of the word drives one request line to the target. The host writes a word in which every 1 raises the matching request. Every 0 leaves its line as it was, so single lines can be rung without reading the word first. The target clears a line with a one-cycle acknowledge pulse once it has serviced that request.

The lines are outputs only and cannot be used as inputs. A host read does not return the last written word. It returns the live pending state of each line: 1 while the target has not yet serviced the request, and 0 once it has. Bits above the line count read as zero and ignore writes. The width of the data word and the number of lines are parameters, with defaults of 32 and 28.

Top module: `doorbell_bank`

## Requirements
- R1: While reset is asserted and after it is released with no activity, every `irq` bit and every `rd_data` bit is 0.
- R2: A clock edge with `wr_en`=1 and `wr_data[i]`=1 (i < LINES) makes `irq[i]` 1 from that edge on.
- R3: A `wr_data` bit of 0 has no effect. A cycle with neither a write nor an acknowledge leaves `irq` unchanged.
- R4: A clock edge with `ack[i]`=1 and no set of bit i makes `irq[i]` 0 from that edge on.
- R5: When a set and an acknowledge of the same bit meet on one edge, the set wins and `irq[i]` is 1 after that edge.
- R6: A clock edge with `rd_en`=1 loads `rd_data[LINES-1:0]` with the pending state of the lines as it stood just before that edge, which equals `irq` in that cycle. Bit i reads 1 for pending and 0 for handled. `rd_data` holds its value while `rd_en` is 0.
- R7: `wr_data` bits LINES to DATA_W-1 (28 to 31 by default) are ignored on write and always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | DATA_W | Host write word; a 1 in bit i rings line i |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | DATA_W | Registered read word: live pending state, upper bits 0 |
| irq | output | LINES | Interrupt request to the target core, one bit per line |
| ack | input | LINES | Target acknowledge pulses, one bit per line |

## Verification
The assertions assume that `wr_en`, `wr_data`, `rd_en` and `ack` are synchronous to `clk`, known after reset, and held at 0 while reset is asserted. Under these assumptions every `$past` term refers to a defined value. The bench changes all inputs only on the falling edge and keeps them at 0 through reset, so every sampled edge sees stable, known values. Acknowledges and writes are sometimes driven in the same cycle on purpose, because the priority between them is a required behaviour.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  // Next pending state of one line: a set always survives a same-cycle clear.
  function automatic logic line_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Set contribution of one write bit.
  function automatic logic line_set(input logic wr_en, input logic bit_val);
    return wr_en & bit_val;
  endfunction

endpackage

// File: rtl/doorbell_host_if.sv
module doorbell_host_if #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINES  = 28
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINES-1:0]  set_mask,
  output logic              wr_upper_hit
);
  import doorbell_pkg::*;

  for (genvar i = 0; i < LINES; i++) begin : g_set
    assign set_mask[i] = line_set(wr_en, wr_data[i]);
  end

  if (DATA_W > LINES) begin : g_upper
    assign wr_upper_hit = wr_en & (|wr_data[DATA_W-1:LINES]);
  end else begin : g_no_upper
    assign wr_upper_hit = 1'b0;
  end
endmodule

// File: rtl/doorbell_cell.sv
module doorbell_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  import doorbell_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= line_next(pend_o, set_i, clr_i);
  end
endmodule

// File: rtl/doorbell_readback.sv
module doorbell_readback #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINES  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [LINES-1:0]  pend,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= DATA_W'(pend);
  end
endmodule

// File: rtl/doorbell_bank.sv
module doorbell_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINES  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LINES-1:0]  irq,
  input  logic [LINES-1:0]  ack
);
  logic [LINES-1:0] set_mask;
  logic [LINES-1:0] pend_vec;
  logic [LINES-1:0] collide;
  logic             wr_upper_hit;

  doorbell_host_if #(.DATA_W(DATA_W), .LINES(LINES)) u_host (
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .set_mask     (set_mask),
    .wr_upper_hit (wr_upper_hit)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    doorbell_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_mask[i]),
      .clr_i  (ack[i]),
      .pend_o (pend_vec[i])
    );
  end

  // Named event for the checker: set and clear meeting on one line.
  assign collide = set_mask & ack;

  doorbell_readback #(.DATA_W(DATA_W), .LINES(LINES)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .pend    (pend_vec),
    .rd_data (rd_data)
  );

  assign irq = pend_vec;
endmodule

// File: rtl/doorbell_bank_chk.sv
module doorbell_bank_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINES  = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [LINES-1:0]  irq,
  input logic [LINES-1:0]  ack,
  input logic [LINES-1:0]  set_mask,
  input logic [LINES-1:0]  collide,
  input logic              wr_upper_hit
);
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((irq & $past(set_mask)) == $past(set_mask))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && ack == '0) |=> $stable(irq)); // R3

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~set_mask) != '0) |=> ((irq & $past(ack & ~set_mask)) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (collide != '0) |=> ((irq & $past(collide)) == $past(collide))); // R5

  AST_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data[LINES-1:0] == $past(irq))); // R6

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_upper_hit || 1'b1) |-> ((rd_data >> LINES) == '0)); // R7
endmodule

bind doorbell_bank doorbell_bank_chk #(.DATA_W(DATA_W), .LINES(LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .irq          (irq),
  .ack          (ack),
  .set_mask     (set_mask),
  .collide      (collide),
  .wr_upper_hit (wr_upper_hit)
);

// File: tb/sim_doorbell_bank.sv
module sim_doorbell_bank;
  localparam int unsigned DW = 32;
  localparam int unsigned NL = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic [NL-1:0] irq;
  logic [NL-1:0] ack = '0;

  int unsigned   errors = 0;
  int unsigned   checks = 0;
  logic [NL-1:0] m_pend = '0;
  logic [DW-1:0] m_rd = '0;
  logic [31:0]   seed = 32'h1234_5678;

  always #5 clk = ~clk;

  doorbell_bank #(.DATA_W(DW), .LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .ack(ack)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  // One cycle of stimulus; the model updates as the edge does, checks 1 ns after it.
  task automatic step(input logic w, input logic [DW-1:0] wd, input logic [NL-1:0] a,
                      input logic r, input string tag_irq, input string tag_rd);
    @(negedge clk);
    wr_en = w; wr_data = wd; ack = a; rd_en = r;
    @(posedge clk);
    if (r) m_rd = {{(DW-NL){1'b0}}, m_pend};
    m_pend = (w ? wd[NL-1:0] : '0) | (m_pend & ~a);
    #1;
    check(tag_irq, {{(DW-NL){1'b0}}, irq}, {{(DW-NL){1'b0}}, m_pend});
    check(tag_rd, rd_data, m_rd);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, '0, 1'b0, tag, tag);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", {{(DW-NL){1'b0}}, irq}, '0);
    check("R1 rd_data in reset", rd_data, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1 after release");
    step(1'b0, '0, '0, 1'b1, "R1", "R1 read after release");

    // Single-bit sweep over the whole word: set, read back, acknowledge.
    for (int i = 0; i < DW; i++) begin
      step(1'b1, DW'(1) << i, '0, 1'b0, (i < NL) ? "R2 set" : "R7 upper write", "R6 hold");
      step(1'b0, '0, '0, 1'b1, "R3 idle", (i < NL) ? "R6 read pending" : "R7 upper read");
      if (i < NL) begin
        step(1'b0, '0, NL'(1) << i, 1'b0, "R4 ack", "R6 hold");
        step(1'b0, '0, '0, 1'b1, "R3 idle", "R6 read handled");
      end
    end

    // Zeros in the write word leave other lines alone.
    step(1'b1, 32'h0AAA_AAAA, '0, 1'b0, "R2 pattern", "R6 hold");
    step(1'b1, 32'h0000_0000, '0, 1'b0, "R3 zero write", "R6 hold");
    step(1'b1, 32'hF555_5555, '0, 1'b1, "R3 merge", "R6 read pattern");
    step(1'b0, '0, '0, 1'b1, "R3 idle", "R6 read full");
    step(1'b0, '0, '1, 1'b0, "R4 ack all", "R6 hold");

    // Set and acknowledge of the same line in one cycle, from clear and from pending.
    for (int i = 0; i < NL; i++) begin
      step(1'b1, DW'(1) << i, NL'(1) << i, 1'b0, "R5 set wins clear", "R6 hold");
      step(1'b1, DW'(1) << i, NL'(1) << i, 1'b1, "R5 set wins pending", "R6 read");
      step(1'b0, '0, NL'(1) << i, 1'b0, "R4 ack", "R6 hold");
    end

    // Mixed traffic over many patterns.
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a;
      logic [31:0] b;
      seed = xs(seed); a = seed;
      seed = xs(seed); b = seed;
      step(b[0], a, b[31:4] & {NL{b[1]}}, b[2], "R2 mixed", "R6 mixed");
    end
    idle("R3 final");
    step(1'b0, '0, '0, 1'b1, "R3", "R7 final read");
    check("R7 upper bits", rd_data >> NL, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule